// File: doc/BRIEF.md
# Word/Byte Arithmetic-Logic Unit with Status Flags

This block is the integer execution core of a 16-bit processor datapath. It takes two 16-bit operands, an operation code, a width select (whole word or low byte) and a carry input. It returns a 16-bit result together with four condition flags: zero, negative, carry and overflow. The operations are add, add with carry, subtract, subtract with borrow, AND, OR, XOR, move, and sign extension of a byte to a word.

The flags are computed combinationally from the active width. In byte mode, negative is taken from bit 7. Carry is the carry out of bit 7, and overflow comes from the carries around bit 7. A status register captures the flags whenever the controller raises a write enable. Its carry bit can then be fed back as the carry input, so that operands wider than 16 bits can be processed one word at a time. Signed branch tests use negative XOR overflow. Unsigned tests use carry.

Top module: `wbalu_top`

## Requirements
- R1: Opcode 0 (add) gives A+B. Opcode 1 (add with carry) gives A+B+carry_in. Carry flag = carry out of the active most significant bit. Chaining the low-word carry into an opcode-1 high-word add gives the correct 32-bit sum.
- R2: Opcode 2 (subtract) gives A-B. Opcode 3 (subtract with borrow) gives A-B-carry_in, where carry_in acts as a borrow. Carry flag = 1 exactly when the unsigned subtraction borrows.
- R3: In word mode, the overflow flag is set for add/subtract exactly when the two's-complement result over bits 15:0 does not fit in 16 signed bits. Negative = bit 15. Zero = all 16 result bits are zero.
- R4: In byte mode (byte_mode=1, any opcode except 8), the operation is applied to bits 7:0 and result bits 15:8 equal op_a bits 15:8.
- R5: In byte mode, zero covers result bits 7:0 only. Negative = bit 7. Carry/borrow and overflow are taken at bit 7 instead of bit 15.
- R6: Opcodes 4/5/6 give A AND B, A OR B and A XOR B. Opcode 7 (move) gives B. All four clear carry and overflow and set zero and negative from the result.
- R7: Opcode 8 gives B[7:0] with bit 7 copied into bits 15:8. It ignores byte_mode, uses word flags, and clears carry and overflow.
- R8: Flag vector bit order is {overflow, carry, negative, zero} (bit 3 down to bit 0). The status register loads flags_now at a clock edge when flag_we=1 and holds its value otherwise.
- R9: A synchronous active-high reset clears the status register to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| opcode | input | 4 | Operation select (0..8) |
| byte_mode | input | 1 | 1 = operate on the low byte |
| carry_in | input | 1 | Carry (add) or borrow (subtract) input |
| flag_we | input | 1 | Status register load enable |
| result | output | 16 | Operation result |
| flags_now | output | 4 | Combinational flags {V,C,N,Z} |
| status | output | 4 | Registered flags {V,C,N,Z} |

## Verification
Every opcode is tried in both widths and with both carry-in values, over a grid of corner operands. The grid includes zero, one, 0x7F, 0x80, 0xFF, 0x7FFF, 0x8000 and 0xFFFF, and mixes whose upper and lower bytes differ in sign. The byte-boundary values separate flags taken at bit 7 from flags taken at bit 15. Operands whose upper byte is nonzero expose any leak of the byte operation into bits 15:8. The signed limits separate a correct overflow rule from a plain carry copy, and the two carry-in values separate borrow sense from carry sense. Two-word add and subtract chains check that the captured carry continues a wider operation correctly, and toggling the write enable separates loading from holding.

// File: rtl/wbalu_pkg.sv
package wbalu_pkg;

    localparam int WORD_W = 16;
    localparam int LANE_W = 8;
    localparam int OPC_W  = 4;
    localparam int FLAG_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBC = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_MOV  = 4'd7,
        OP_SEXT = 4'd8
    } alu_op_e;

    typedef struct packed {
        logic v;
        logic c;
        logic n;
        logic z;
    } alu_flags_t;

    function automatic logic op_is_arith(alu_op_e op);
        return (op == OP_ADD) || (op == OP_ADDC) || (op == OP_SUB) || (op == OP_SUBC);
    endfunction

    function automatic logic op_is_sub(alu_op_e op);
        return (op == OP_SUB) || (op == OP_SUBC);
    endfunction

endpackage

// File: rtl/wbalu_adder.sv
module wbalu_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic [W:0]   carry   // carry[i] = carry into bit i, carry[W] = carry out
);
    assign carry[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]     = a[i] ^ b[i] ^ carry[i];
        assign carry[i+1] = (a[i] & b[i]) | (a[i] & carry[i]) | (b[i] & carry[i]);
    end
endmodule

// File: rtl/wbalu_logic.sv
module wbalu_logic
    import wbalu_pkg::*;
#(
    parameter int W  = 16,
    parameter int BW = 8
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);
    always_comb begin
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_SEXT: res = {{(W-BW){b[BW-1]}}, b[BW-1:0]};
            default: res = b;
        endcase
    end
endmodule

// File: rtl/wbalu_flaggen.sv
module wbalu_flaggen
    import wbalu_pkg::*;
#(
    parameter int W  = 16,
    parameter int BW = 8
) (
    input  logic [W-1:0] res,
    input  logic [W:0]   carry,
    input  logic         byte_sel,
    input  logic         arith,
    input  logic         sub,
    output alu_flags_t   flags
);
    logic top_out, top_in;

    always_comb begin
        if (byte_sel) begin
            flags.z = (res[BW-1:0] == '0);
            flags.n = res[BW-1];
            top_out = carry[BW];
            top_in  = carry[BW-1];
        end else begin
            flags.z = (res == '0);
            flags.n = res[W-1];
            top_out = carry[W];
            top_in  = carry[W-1];
        end
        // subtraction reports borrow: the inverted adder carry
        flags.c = arith & (top_out ^ sub);
        flags.v = arith & (top_out ^ top_in);
    end
endmodule

// File: rtl/wbalu_top.sv
module wbalu_top
    import wbalu_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    parameter int BYTE_W = LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [OPC_W-1:0]  opcode,
    input  logic              byte_mode,
    input  logic              carry_in,
    input  logic              flag_we,
    output logic [DATA_W-1:0] result,
    output logic [FLAG_W-1:0] flags_now,
    output logic [FLAG_W-1:0] status
);
    alu_op_e           op;
    logic              arith, sub, byte_sel, add_cin;
    logic [DATA_W-1:0] b_eff, sum, logic_res, full_res;
    logic [DATA_W:0]   carry;
    alu_flags_t        flags_c, status_q;

    assign op       = alu_op_e'(opcode);
    assign arith    = op_is_arith(op);
    assign sub      = op_is_sub(op);
    assign byte_sel = byte_mode && (op != OP_SEXT);
    assign b_eff    = sub ? ~op_b : op_b;

    always_comb begin
        unique case (op)
            OP_ADDC: add_cin = carry_in;
            OP_SUB:  add_cin = 1'b1;
            OP_SUBC: add_cin = ~carry_in;
            default: add_cin = 1'b0;
        endcase
    end

    wbalu_adder #(.W(DATA_W)) u_add (
        .a     (op_a),
        .b     (b_eff),
        .cin   (add_cin),
        .sum   (sum),
        .carry (carry)
    );

    wbalu_logic #(.W(DATA_W), .BW(BYTE_W)) u_log (
        .op  (op),
        .a   (op_a),
        .b   (op_b),
        .res (logic_res)
    );

    assign full_res = arith ? sum : logic_res;
    assign result   = byte_sel ? {op_a[DATA_W-1:BYTE_W], full_res[BYTE_W-1:0]} : full_res;

    wbalu_flaggen #(.W(DATA_W), .BW(BYTE_W)) u_flg (
        .res      (result),
        .carry    (carry),
        .byte_sel (byte_sel),
        .arith    (arith),
        .sub      (sub),
        .flags    (flags_c)
    );

    always_ff @(posedge clk) begin
        if (rst)          status_q <= '0;
        else if (flag_we) status_q <= flags_c;
    end

    assign flags_now = flags_c;
    assign status    = status_q;
endmodule

// File: rtl/wbalu_checker.sv
module wbalu_checker
    import wbalu_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    parameter int BYTE_W = LANE_W
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] op_a,
    input logic [OPC_W-1:0]  opcode,
    input logic              byte_mode,
    input logic              flag_we,
    input logic [DATA_W-1:0] result,
    input logic [FLAG_W-1:0] flags_now,
    input logic [FLAG_W-1:0] status
);
    logic byte_act, logic_op, sext_op;
    assign sext_op  = (opcode == OP_SEXT);
    assign byte_act = byte_mode && !sext_op;
    assign logic_op = (opcode == OP_AND) || (opcode == OP_OR) ||
                      (opcode == OP_XOR) || (opcode == OP_MOV);

    p_status_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !flag_we |=> $stable(status));

    p_status_load_r8: assert property (@(posedge clk) disable iff (rst)
        flag_we |=> status == $past(flags_now));

    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> status == '0);

    p_logic_no_cv_r6: assert property (@(posedge clk) disable iff (rst)
        logic_op |-> flags_now[3:2] == 2'b00);

    p_byte_upper_r4: assert property (@(posedge clk) disable iff (rst)
        byte_act |-> result[DATA_W-1:BYTE_W] == op_a[DATA_W-1:BYTE_W]);

    p_byte_neg_r5: assert property (@(posedge clk) disable iff (rst)
        byte_act |-> flags_now[1] == result[BYTE_W-1]);

    p_sext_upper_r7: assert property (@(posedge clk) disable iff (rst)
        sext_op |-> result[DATA_W-1:BYTE_W] == {(DATA_W-BYTE_W){result[BYTE_W-1]}});
endmodule

bind wbalu_top wbalu_checker #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_a      (op_a),
    .opcode    (opcode),
    .byte_mode (byte_mode),
    .flag_we   (flag_we),
    .result    (result),
    .flags_now (flags_now),
    .status    (status)
);

// File: tb/wbalu_top_tb.sv
module wbalu_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] PAT [12] = '{16'h0000, 16'h0001, 16'h007F, 16'h0080,
                                         16'h00FF, 16'h7FFF, 16'h8000, 16'hFFFF,
                                         16'hFF80, 16'h1234, 16'h80FF, 16'h7F00};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] op_a = '0, op_b = '0;
    logic [3:0]  opcode = '0;
    logic        byte_mode = 1'b0, carry_in = 1'b0, flag_we = 1'b0;
    logic [15:0] result;
    logic [3:0]  flags_now, status;

    int          checks = 0;
    int          errors = 0;
    logic [3:0]  exp_status = '0;
    logic [19:0] last_exp;

    always #(CLK_PERIOD/2) clk = ~clk;

    wbalu_top u_dut (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .opcode(opcode),
        .byte_mode(byte_mode), .carry_in(carry_in), .flag_we(flag_we),
        .result(result), .flags_now(flags_now), .status(status)
    );

    // returns {V,C,N,Z,result}
    function automatic logic [19:0] model(input logic [3:0] op, input logic [15:0] a,
                                          input logic [15:0] b, input logic bm,
                                          input logic ci);
        logic [16:0] w;
        logic [8:0]  by;
        logic [15:0] r, lr;
        logic        z, n, c, v, wide;
        logic        cx;
        wide = !bm || (op == 4'd8);
        c = 1'b0; v = 1'b0; r = '0;
        case (op)
            4'd0, 4'd1: begin
                cx = (op == 4'd1) ? ci : 1'b0;
                if (wide) begin
                    w = {1'b0, a} + {1'b0, b} + {16'd0, cx};
                    r = w[15:0]; c = w[16];
                    v = (a[15] == b[15]) && (r[15] != a[15]);
                end else begin
                    by = {1'b0, a[7:0]} + {1'b0, b[7:0]} + {8'd0, cx};
                    r = {a[15:8], by[7:0]}; c = by[8];
                    v = (a[7] == b[7]) && (r[7] != a[7]);
                end
            end
            4'd2, 4'd3: begin
                cx = (op == 4'd3) ? ci : 1'b0;
                if (wide) begin
                    w = {1'b0, a} - {1'b0, b} - {16'd0, cx};
                    r = w[15:0]; c = w[16];
                    v = (a[15] != b[15]) && (r[15] != a[15]);
                end else begin
                    by = {1'b0, a[7:0]} - {1'b0, b[7:0]} - {8'd0, cx};
                    r = {a[15:8], by[7:0]}; c = by[8];
                    v = (a[7] != b[7]) && (r[7] != a[7]);
                end
            end
            4'd8: r = {{8{b[7]}}, b[7:0]};
            default: begin
                case (op)
                    4'd4: lr = a & b;
                    4'd5: lr = a | b;
                    4'd6: lr = a ^ b;
                    default: lr = b;
                endcase
                r = wide ? lr : {a[15:8], lr[7:0]};
            end
        endcase
        if (wide) begin z = (r == 16'd0);   n = r[15]; end
        else      begin z = (r[7:0] == 8'd0); n = r[7]; end
        return {v, c, n, z, r};
    endfunction

    function automatic string op_tag(input logic [3:0] op);
        if (op < 4'd2)       return "R1";
        else if (op < 4'd4)  return "R2";
        else if (op < 4'd8)  return "R6";
        else                 return "R7";
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b,
                           input logic bm, input logic ci, input logic we);
        logic [19:0] e;
        string rt, ft;
        @(negedge clk);
        opcode = op; op_a = a; op_b = b; byte_mode = bm; carry_in = ci; flag_we = we;
        #1;
        e = model(op, a, b, bm, ci);
        last_exp = e;
        if (bm && op != 4'd8) begin rt = "R4"; ft = "R5"; end
        else begin rt = op_tag(op); ft = (op < 4'd4) ? "R3" : op_tag(op); end
        chk(rt, result, e[15:0]);
        chk(ft, {12'd0, flags_now}, {12'd0, e[19:16]});
        @(posedge clk);
        #1;
        if (we) exp_status = e[19:16];
        chk("R8", {12'd0, status}, {12'd0, exp_status});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lo, hi;
        logic        cy;
        int          n;
        // reset state
        repeat (2) @(posedge clk);
        #1;
        chk("R9", {12'd0, status}, 16'd0);
        @(negedge clk);
        rst = 1'b0;

        // grid sweep over every opcode, width, carry-in and operand pair
        n = 0;
        for (int op = 0; op < 9; op++)
            for (int bm = 0; bm < 2; bm++)
                for (int ia = 0; ia < 12; ia++)
                    for (int ib = 0; ib < 12; ib++)
                        for (int ci = 0; ci < 2; ci++) begin
                            run_vec(4'(op), PAT[ia], PAT[ib], 1'(bm), 1'(ci), (n % 3) != 0);
                            n++;
                        end

        // two-word add chain: 0x0001FFFF + 0x00000001 = 0x00020000 (R1)
        run_vec(4'd0, 16'hFFFF, 16'h0001, 1'b0, 1'b0, 1'b1);
        lo = result; cy = status[2];
        run_vec(4'd1, 16'h0001, 16'h0000, 1'b0, cy, 1'b1);
        hi = result;
        chk("R1", hi, 16'h0002);
        chk("R1", lo, 16'h0000);

        // two-word subtract chain: 0x00020000 - 0x00000001 = 0x0001FFFF (R2)
        run_vec(4'd2, 16'h0000, 16'h0001, 1'b0, 1'b0, 1'b1);
        lo = result; cy = status[2];
        run_vec(4'd3, 16'h0002, 16'h0000, 1'b0, cy, 1'b1);
        hi = result;
        chk("R2", hi, 16'h0001);
        chk("R2", lo, 16'hFFFF);

        // byte chain: 0x01FF + 0x0001 as two byte adds gives low byte 00, high byte 02 (R5)
        run_vec(4'd0, 16'h00FF, 16'h0001, 1'b1, 1'b0, 1'b1);
        chk("R5", {15'd0, status[2]}, 16'd1);

        // mid-run reset after loading nonzero flags (R9)
        run_vec(4'd2, 16'h0000, 16'h0001, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        flag_we = 1'b1;
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk("R9", {12'd0, status}, 16'd0);
        exp_status = '0;
        @(negedge clk);
        rst = 1'b0;
        flag_we = 1'b0;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule